// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is a finite state machine whose transitions are held in a synchronous read-only memory rather than in gate logic. Each memory word carries three fields: the address of the following word, a code that picks which branch condition (if any) takes part, and the control bits that the state drives. At every enabled clock edge the condition value chosen by the select code is ORed into the low bits of the stored next address. That result becomes both the new current address and the memory read address. A state that does not branch therefore takes one word. A state that branches takes one aligned group of words.

The memory read is registered, and the control outputs come straight from that registered data. The current address and the control bits therefore always belong to the same word. The memory enable follows a lock qualifier from the clock source. While the clock is not locked, neither the memory output nor the address register changes. The condition inputs must already be synchronous to the sequencer clock. The program image is a constant function in the package.

Top module: `mseq_core`

## Requirements
- R1: A synchronous active-high reset sets `addr_o` to 0 and `ctrl_o` to the control field of word 0. This happens whatever the lock input is. Both values appear at the first clock edge with reset high.
- R2: With select code 0, the next address equals the stored next-address field exactly, whatever the condition inputs are.
- R3: With select code 1, `cond_i[0]` is ORed into bit 0 of the next-address field.
- R4: With select code 2, `cond_i[1]` is ORed into bit 0 of the next-address field.
- R5: With select code 3, the two-bit value `cond_i[1:0]` is ORed into bits 1:0 of the next-address field, which gives a four-way branch.
- R6: `ctrl_o` always equals the control field of the word at `addr_o`, with one clock of latency from the address decision.
- R7: While `clk_locked` is low, `addr_o` and `ctrl_o` hold their values and changes on `cond_i` have no effect. Sequencing resumes from the held word when lock returns.
- R8: The store has 64 words with a 6-bit address. Every word with a nonzero select code has its next-address low 2 bits at 0. An address computed past the last block wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_locked | input | 1 | Clock source lock; acts as the memory and address enable |
| cond_i | input | 2 | Branch condition inputs, already synchronous |
| ctrl_o | output | 8 | Registered control bits of the current word |
| addr_o | output | 6 | Current microword address |

## Verification
The program is walked with the conditions held at all zeros, held at all ones, and alternating between single-bit patterns. The all-zero walk shows that a selected condition adds nothing when it is low. The all-ones walk shows which bit each select code ORs in. The alternating walk separates a select of condition 0 from a select of condition 1. Lock is dropped in the middle of a walk while the conditions toggle, which shows that both the address and the control outputs hold. A reset asserted during a run, with lock low, shows that reset does not depend on the enable.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int ADDR_W = 6;
    localparam int COND_W = 2;
    localparam int SEL_W  = 2;
    localparam int CTRL_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NSEL   = 1 << SEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] nxt;
        logic [SEL_W-1:0]  sel;
        logic [CTRL_W-1:0] ctrl;
    } mseq_word_t;

    // Program image: blocks of 2**COND_W words; each block head branches
    // with a select code taken from its block index, other words fall through.
    function automatic mseq_word_t mseq_prog(input logic [ADDR_W-1:0] a);
        mseq_word_t w;
        logic [ADDR_W-1:0] blk;
        blk    = ADDR_W'((a >> COND_W) + 1);
        w.nxt  = ADDR_W'(blk << COND_W);
        w.sel  = (a[COND_W-1:0] == '0) ? SEL_W'(a >> COND_W) : '0;
        w.ctrl = CTRL_W'(a * 37 + 11);
        return w;
    endfunction

endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
    import mseq_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [COND_W-1:0] cond,
    output logic [COND_W-1:0] mask
);

    logic [COND_W-1:0] opts [NSEL];

    assign opts[0] = '0;

    for (genvar k = 1; k < NSEL; k++) begin : g_opt
        if (k <= COND_W) begin : g_single
            assign opts[k] = COND_W'(cond[k-1]);
        end else begin : g_all
            assign opts[k] = cond;
        end
    end

    assign mask = opts[sel];

endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [ADDR_W-1:0] raddr,
    output mseq_word_t        q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= mseq_prog('0);
        end else if (ce) begin
            q <= mseq_prog(raddr);
        end
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_locked,
    input  logic [COND_W-1:0] cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] addr_o
);

    mseq_word_t        rom_q;
    logic [COND_W-1:0] br_mask;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  cur_sel;
    logic [ADDR_W-1:0] cur_nxt;

    assign cur_sel = rom_q.sel;
    assign cur_nxt = rom_q.nxt;

    mseq_cond_mux u_mux (
        .sel  (cur_sel),
        .cond (cond_i),
        .mask (br_mask)
    );

    assign nxt_addr = cur_nxt | ADDR_W'(br_mask);

    mseq_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .ce    (clk_locked),
        .raddr (nxt_addr),
        .q     (rom_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (clk_locked) begin
            addr_q <= nxt_addr;
        end
    end

    assign addr_o = addr_q;
    assign ctrl_o = rom_q.ctrl;

endmodule

// File: rtl/mseq_core_chk.sv
module mseq_core_chk
    import mseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lock,
    input logic [COND_W-1:0] cond,
    input logic [ADDR_W-1:0] addr,
    input logic [CTRL_W-1:0] ctrl,
    input logic [SEL_W-1:0]  w_sel,
    input logic [ADDR_W-1:0] w_nxt
);

    p_reset_addr_r1: assert property (@(posedge clk)
        rst |=> (addr == '0));

    p_nobranch_r2: assert property (@(posedge clk) disable iff (rst)
        (lock && w_sel == '0) |=> (addr == $past(w_nxt)));

    p_fourway_r5: assert property (@(posedge clk) disable iff (rst)
        (lock && w_sel == '1) |=> (addr == ($past(w_nxt) | ADDR_W'($past(cond)))));

    p_ctrl_match_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl == mseq_prog(addr).ctrl);

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !lock |=> ($stable(addr) && $stable(ctrl)));

    p_align_r8: assert property (@(posedge clk) disable iff (rst)
        (w_sel != '0) |-> (w_nxt[COND_W-1:0] == '0));

endmodule

bind mseq_core mseq_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .lock  (clk_locked),
    .cond  (cond_i),
    .addr  (addr_o),
    .ctrl  (ctrl_o),
    .w_sel (cur_sel),
    .w_nxt (cur_nxt)
);

// File: tb/mseq_core_bench.sv
`timescale 1ns/1ps
module mseq_core_bench;
    import mseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_locked = 1'b0;
    logic [COND_W-1:0] cond_i = '0;
    logic [CTRL_W-1:0] ctrl_o;
    logic [ADDR_W-1:0] addr_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #2 clk = ~clk;

    mseq_core u_mseq_core (
        .clk        (clk),
        .rst        (rst),
        .clk_locked (clk_locked),
        .cond_i     (cond_i),
        .ctrl_o     (ctrl_o),
        .addr_o     (addr_o)
    );

    task automatic check(input string req);
        logic [CTRL_W-1:0] ec;
        ec = mseq_prog(exp_addr).ctrl;
        n_run++;
        if (addr_o !== exp_addr) begin
            n_fail++;
            $display("FAIL %s addr actual %0d expected %0d", req, addr_o, exp_addr);
        end
        n_run++;
        if (ctrl_o !== ec) begin
            n_fail++;
            $display("FAIL %s/R6 ctrl actual %0h expected %0h", req, ctrl_o, ec);
        end
    endtask

    // One clock: drive at negedge, result sampled at the following negedge.
    task automatic step(input logic lk, input logic [COND_W-1:0] c);
        mseq_word_t w;
        logic [COND_W-1:0] m;
        logic [ADDR_W-1:0] old;
        string req;
        clk_locked = lk;
        cond_i     = c;
        old        = exp_addr;
        w          = mseq_prog(exp_addr);
        if (!lk) begin
            req = "R7";
        end else begin
            case (w.sel)
                2'd0: begin m = '0;              req = "R2"; end
                2'd1: begin m = {1'b0, c[0]};    req = "R3"; end
                2'd2: begin m = {1'b0, c[1]};    req = "R4"; end
                default: begin m = c;            req = "R5"; end
            endcase
            exp_addr = w.nxt | ADDR_W'(m);
            if (exp_addr < old) req = "R8";
        end
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clk_locked = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_addr = '0;
        check("R1");
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        do_reset();
    endtask

    task automatic t_walk_zero();
        for (int i = 0; i < 20; i++) step(1'b1, 2'b00);
    endtask

    task automatic t_walk_ones();
        for (int i = 0; i < 40; i++) step(1'b1, 2'b11);
    endtask

    task automatic t_walk_mixed();
        for (int i = 0; i < 40; i++) step(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10);
    endtask

    task automatic t_lock_hold();
        for (int i = 0; i < 5; i++) step(1'b1, 2'b00);
        for (int i = 0; i < 6; i++) step(1'b0, COND_W'(i));
        for (int i = 0; i < 8; i++) step(1'b1, 2'b11);
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 7; i++) step(1'b1, 2'b01);
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 2'b10);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_walk_zero();
        t_walk_ones();
        t_walk_mixed();
        t_lock_hold();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule